// File: doc/BRIEF.md
# Audio Sample FIFO with Threshold DMA Requests

This block holds two sample buffers between a DMA engine and a serial audio shifter. The transmit buffer is filled by the DMA engine and drained one word at a time by the shifter. The receive buffer is filled by the shifter and drained by the DMA engine. Each direction drives a level-sensitive DMA request line. Every acknowledge pulse taken while that line is high moves exactly one word.

A request can be raised in one of two ways. In per-word mode a request covers a single word, and the programmed threshold has no effect. In burst mode a request covers a burst of threshold-plus-one words, which is how software matches one burst to one audio period. When transmit is switched on, the block first primes the buffer: the request stays high until the transmit buffer is completely full. Only after that does the normal threshold rule take over. When a burst finishes, the request drops for at least one cycle and the block then evaluates it again.

A small write-only register port sets the enables, the request mode and the two thresholds. The same port clears the two sticky error flags. Fill levels and error flags are brought out as ports.

Top module: `audfifo_dma`

## Requirements
- R1: Reset empties both buffers, drives both request lines low and clears both error flags.
- R2: In burst mode (control bit 2 = 1), the receive request rises once the receive level is at least the receive threshold plus one. It then stays high for exactly threshold-plus-one accepted acknowledges. Each acknowledge pops one word, and `rxDmaData` shows the words in arrival order.
- R3: In per-word mode (control bit 2 = 0), every request covers exactly one word, whatever threshold value is programmed.
- R4: Setting the transmit enable (control bit 0) raises `txDmaReq` one cycle after the register write. The line stays high until the transmit level equals the buffer depth, and each accepted acknowledge stores `txDmaData`.
- R5: After priming, the transmit request rises once the free space is at least the transmit threshold plus one, and it covers threshold-plus-one acknowledges.
- R6: When a burst ends, the request drops for at least one cycle. One cycle later it rises again if the condition for a new burst holds.
- R7: An acknowledge that arrives while its request line is low changes nothing.
- R8: A write to a threshold register (address 1 for transmit, address 2 for receive) is ignored while that direction is enabled (control bit 0 for transmit, bit 1 for receive; control is address 0).
- R9: A shifter pop from an empty transmit buffer sets `txUnderflow` and returns zero. A shifter push into a full receive buffer sets `rxOverflow` and drops the word. Both flags are sticky.
- R10: Writing address 3 clears `txUnderflow` when bit 0 is one and `rxOverflow` when bit 1 is one. Flags whose bit is zero are left unchanged.
- R11: Words popped by the shifter come out in the order the DMA engine wrote them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 control, 1 tx threshold, 2 rx threshold, 3 flag clear) |
| regWrData | input | REG_DW | Register write data |
| txDmaReq | output | 1 | Transmit DMA request |
| txDmaAck | input | 1 | Transmit acknowledge, one word per pulse |
| txDmaData | input | WIDTH | Word written into the transmit buffer |
| rxDmaReq | output | 1 | Receive DMA request |
| rxDmaAck | input | 1 | Receive acknowledge, one word per pulse |
| rxDmaData | output | WIDTH | Head word of the receive buffer |
| txPop | input | 1 | Shifter takes one transmit word |
| txPopData | output | WIDTH | Head word of the transmit buffer (zero when empty) |
| rxPush | input | 1 | Shifter delivers one receive word |
| rxPushData | input | WIDTH | Received word |
| txLevel | output | LVL_W | Transmit fill level |
| rxLevel | output | LVL_W | Receive fill level |
| txUnderflow | output | 1 | Sticky transmit underflow flag |
| rxOverflow | output | 1 | Sticky receive overflow flag |

## Verification
The bench builds the block with a depth of eight words and a 16-bit word. With these values the buffers fill to the brim in a handful of cycles, and a threshold of seven covers the entire buffer as a single burst. Priming to full, overflow on the ninth push and underflow on an empty pop each take only a few cycles, so every boundary is exercised directly rather than reached through long fills.

// File: rtl/audfifo_pkg.sv
package audfifo_pkg;
  // register addresses
  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_TXTHR = 2'd1;
  localparam logic [1:0] ADDR_RXTHR = 2'd2;
  localparam logic [1:0] ADDR_CLR   = 2'd3;
  // control bit positions
  localparam int CTRL_TX_EN = 0;
  localparam int CTRL_RX_EN = 1;
  localparam int CTRL_BURST = 2;

  typedef struct packed {
    logic wr;
    logic rd;
  } fifoStrobe_t;
endpackage

// File: rtl/audfifo_buf.sv
module audfifo_buf
  import audfifo_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 1024,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      stb,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [LVL_W-1:0] level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic wrEff, rdEff;

  assign wrEff  = stb.wr && (level != LVL_W'(DEPTH));
  assign rdEff  = stb.rd && (level != '0);
  assign rdData = (level == '0) ? '0 : mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wrEff) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (wrEff) wrPtr <= nextPtr(wrPtr);
      if (rdEff) rdPtr <= nextPtr(rdPtr);
      case ({wrEff, rdEff})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));
  assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.wr && !stb.rd) |=> $stable(level));
endmodule

// File: rtl/audfifo_ctrl.sv
module audfifo_ctrl
  import audfifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter bit IS_TX = 1'b1,
  localparam int THR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             burstMode,
  input  logic [THR_W-1:0] thr,
  input  logic [LVL_W-1:0] level,
  input  logic             dmaAck,
  input  logic             shiftStrobe,
  output logic             req,
  output fifoStrobe_t      stb,
  output logic             errPulse
);
  logic [LVL_W-1:0] burstLeft, burstLen, avail;
  logic [THR_W-1:0] thrEff;
  logic priming, enPrev, full, empty, ackAcc;

  assign full     = (level == LVL_W'(DEPTH));
  assign empty    = (level == '0);
  assign avail    = IS_TX ? (LVL_W'(DEPTH) - level) : level;
  assign thrEff   = burstMode ? thr : '0;
  assign burstLen = LVL_W'(thrEff) + LVL_W'(1);
  assign req      = enable && (priming ? !full : (burstLeft != '0));
  assign ackAcc   = dmaAck && req;

  always_comb begin
    if (IS_TX) begin
      stb.wr   = ackAcc;
      stb.rd   = shiftStrobe && !empty;
      errPulse = shiftStrobe && empty;
    end else begin
      stb.wr   = shiftStrobe && !full;
      stb.rd   = ackAcc;
      errPulse = shiftStrobe && full;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstLeft <= '0;
      priming   <= 1'b0;
      enPrev    <= 1'b0;
    end else begin
      enPrev <= enable;
      if (!enable) begin
        burstLeft <= '0;
        priming   <= 1'b0;
      end else if (IS_TX && !enPrev) begin
        priming   <= 1'b1;
        burstLeft <= '0;
      end else if (priming) begin
        if (full) priming <= 1'b0;
      end else if (burstLeft != '0) begin
        if (ackAcc) burstLeft <= burstLeft - LVL_W'(1);
      end else if (avail >= burstLen) begin
        burstLeft <= burstLen;
      end
    end
  end

  // an accepted acknowledge always finds room (tx) or data (rx)
  assert_ack_room_R2: assert property (@(posedge clk) disable iff (!rstN)
    ackAcc |-> (IS_TX ? !full : !empty));
  // priming only ends on a full buffer while still enabled
  assert_prime_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && $fell(priming)) |-> $past(full));
  // a burst never overruns its count
  assert_burst_cap_R5: assert property (@(posedge clk) disable iff (!rstN)
    burstLeft <= LVL_W'(DEPTH));
endmodule

// File: rtl/audfifo_regs.sv
module audfifo_regs
  import audfifo_pkg::*;
#(
  parameter int THR_W  = 10,
  parameter int REG_DW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_DW-1:0] regWrData,
  input  logic              txErr,
  input  logic              rxErr,
  output logic              txEnable,
  output logic              rxEnable,
  output logic              burstMode,
  output logic [THR_W-1:0]  txThr,
  output logic [THR_W-1:0]  rxThr,
  output logic              txUnderflow,
  output logic              rxOverflow
);
  logic clrTx, clrRx;
  assign clrTx = regWrEn && (regAddr == ADDR_CLR) && regWrData[0];
  assign clrRx = regWrEn && (regAddr == ADDR_CLR) && regWrData[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEnable    <= 1'b0;
      rxEnable    <= 1'b0;
      burstMode   <= 1'b0;
      txThr       <= '0;
      rxThr       <= '0;
      txUnderflow <= 1'b0;
      rxOverflow  <= 1'b0;
    end else begin
      if (regWrEn && regAddr == ADDR_CTRL) begin
        txEnable  <= regWrData[CTRL_TX_EN];
        rxEnable  <= regWrData[CTRL_RX_EN];
        burstMode <= regWrData[CTRL_BURST];
      end
      if (regWrEn && regAddr == ADDR_TXTHR && !txEnable) txThr <= regWrData[THR_W-1:0];
      if (regWrEn && regAddr == ADDR_RXTHR && !rxEnable) rxThr <= regWrData[THR_W-1:0];
      txUnderflow <= txErr || (txUnderflow && !clrTx);
      rxOverflow  <= rxErr || (rxOverflow && !clrRx);
    end
  end

  assert_thr_locked_R8: assert property (@(posedge clk) disable iff (!rstN)
    txEnable |=> $stable(txThr));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (txUnderflow && !clrTx) |=> txUnderflow);
endmodule

// File: rtl/audfifo_dma.sv
module audfifo_dma
  import audfifo_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 1024,
  localparam int THR_W  = $clog2(DEPTH),
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int REG_DW = (THR_W > 3) ? THR_W : 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_DW-1:0] regWrData,
  output logic              txDmaReq,
  input  logic              txDmaAck,
  input  logic [WIDTH-1:0]  txDmaData,
  output logic              rxDmaReq,
  input  logic              rxDmaAck,
  output logic [WIDTH-1:0]  rxDmaData,
  input  logic              txPop,
  output logic [WIDTH-1:0]  txPopData,
  input  logic              rxPush,
  input  logic [WIDTH-1:0]  rxPushData,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              txUnderflow,
  output logic              rxOverflow
);
  logic txEnable, rxEnable, burstMode, txErr, rxErr;
  logic [THR_W-1:0] txThr, rxThr;
  fifoStrobe_t txStb, rxStb;

  audfifo_regs #(.THR_W(THR_W), .REG_DW(REG_DW)) u_regs (
    .clk, .rstN, .regWrEn, .regAddr, .regWrData,
    .txErr, .rxErr, .txEnable, .rxEnable, .burstMode,
    .txThr, .rxThr, .txUnderflow, .rxOverflow
  );

  audfifo_ctrl #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_txCtrl (
    .clk, .rstN, .enable(txEnable), .burstMode, .thr(txThr), .level(txLevel),
    .dmaAck(txDmaAck), .shiftStrobe(txPop), .req(txDmaReq), .stb(txStb),
    .errPulse(txErr)
  );

  audfifo_ctrl #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rxCtrl (
    .clk, .rstN, .enable(rxEnable), .burstMode, .thr(rxThr), .level(rxLevel),
    .dmaAck(rxDmaAck), .shiftStrobe(rxPush), .req(rxDmaReq), .stb(rxStb),
    .errPulse(rxErr)
  );

  audfifo_buf #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txBuf (
    .clk, .rstN, .stb(txStb), .wrData(txDmaData), .rdData(txPopData), .level(txLevel)
  );

  audfifo_buf #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxBuf (
    .clk, .rstN, .stb(rxStb), .wrData(rxPushData), .rdData(rxDmaData), .level(rxLevel)
  );
endmodule

// File: tb/audfifo_dma_bench.sv
module audfifo_dma_bench;
  localparam int WIDTH = 16;
  localparam int DEPTH = 8;
  localparam int LVL_W = 4;
  localparam int REG_DW = 3;

  logic clk = 1'b0, rstN;
  logic regWrEn;
  logic [1:0] regAddr;
  logic [REG_DW-1:0] regWrData;
  logic txDmaReq, txDmaAck, rxDmaReq, rxDmaAck, txPop, rxPush;
  logic [WIDTH-1:0] txDmaData, rxDmaData, txPopData, rxPushData;
  logic [LVL_W-1:0] txLevel, rxLevel;
  logic txUnderflow, rxOverflow;
  int nChecks = 0, nFail = 0;

  always #5 clk = ~clk;

  audfifo_dma #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_audfifo_dma (.*);

  typedef struct packed {
    logic       mode;
    logic [3:0] thr;
    logic [4:0] pushes;
    logic       expReq;
    logic [4:0] burst;
  } rxVec_t;
  localparam int NV = 7;
  localparam rxVec_t RXV [NV] = '{
    '{1'b1, 4'd3, 5'd3, 1'b0, 5'd0},
    '{1'b1, 4'd3, 5'd4, 1'b1, 5'd4},
    '{1'b0, 4'd5, 5'd1, 1'b1, 5'd1},
    '{1'b1, 4'd7, 5'd8, 1'b1, 5'd8},
    '{1'b1, 4'd0, 5'd2, 1'b1, 5'd1},
    '{1'b1, 4'd7, 5'd7, 1'b0, 5'd0},
    '{1'b0, 4'd5, 5'd3, 1'b1, 5'd1}
  };

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [REG_DW-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    cyc();
    regWrEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cyc(); cyc();
    rstN = 1'b1;
    cyc();
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=0 expected=1");
    finishRun();
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    txDmaAck = 1'b0; txDmaData = '0; rxDmaAck = 1'b0;
    txPop = 1'b0; rxPush = 1'b0; rxPushData = '0;
    doReset();
    // R1 reset state
    chk(txDmaReq == 1'b0 && rxDmaReq == 1'b0, "R1 requests", {txDmaReq, rxDmaReq}, 0);
    chk(txLevel == 0 && rxLevel == 0, "R1 levels", {txLevel, rxLevel}, 0);
    chk(!txUnderflow && !rxOverflow, "R1 flags", {txUnderflow, rxOverflow}, 0);

    // receive table walk: R2, R3, R6
    for (int v = 0; v < NV; v++) begin
      int got;
      int base;
      string tag;
      tag = RXV[v].mode ? "R2" : "R3";
      base = 16'h0100 + v * 16;
      doReset();
      wrReg(2'd2, 3'(RXV[v].thr));
      wrReg(2'd0, {RXV[v].mode, 1'b1, 1'b0});
      for (int i = 0; i < int'(RXV[v].pushes); i++) begin
        rxPush = 1'b1; rxPushData = WIDTH'(base + i);
        cyc();
      end
      rxPush = 1'b0;
      cyc(); cyc();
      chk(rxDmaReq == RXV[v].expReq, tag, rxDmaReq, RXV[v].expReq);
      if (RXV[v].expReq) begin
        got = 0;
        while (rxDmaReq && got < 16) begin
          chk(rxDmaData == WIDTH'(base + got), tag, rxDmaData, base + got);
          rxDmaAck = 1'b1;
          cyc();
          rxDmaAck = 1'b0;
          got++;
        end
        chk(got == int'(RXV[v].burst), tag, got, RXV[v].burst);
        cyc();
        chk(rxDmaReq == ((int'(RXV[v].pushes) - got) >= got), "R6", rxDmaReq,
            (int'(RXV[v].pushes) - got) >= got);
      end
    end

    // R7: acknowledge with request low
    doReset();
    txDmaAck = 1'b1; txDmaData = 16'hBAD0;
    rxDmaAck = 1'b1;
    cyc();
    txDmaAck = 1'b0; rxDmaAck = 1'b0;
    chk(txLevel == 0 && rxLevel == 0, "R7", {txLevel, rxLevel}, 0);

    // R4: transmit priming
    wrReg(2'd1, 3'd2);
    wrReg(2'd0, 3'b101);
    chk(txDmaReq == 1'b0, "R4 latency", txDmaReq, 0);
    cyc();
    chk(txDmaReq == 1'b1, "R4 start", txDmaReq, 1);
    begin
      int got = 0;
      while (txDmaReq && got < 20) begin
        txDmaAck = 1'b1; txDmaData = WIDTH'(16'h0200 + got);
        cyc();
        got++;
      end
      txDmaAck = 1'b0;
      chk(got == DEPTH, "R4 prime count", got, DEPTH);
      chk(txLevel == DEPTH, "R4 full", txLevel, DEPTH);
    end

    // R11 + R5: pops then threshold burst
    chk(txPopData == 16'h0200, "R11", txPopData, 16'h0200);
    txPop = 1'b1; cyc();
    chk(txPopData == 16'h0201, "R11", txPopData, 16'h0201);
    cyc(); txPop = 1'b0;
    cyc(); cyc();
    chk(txDmaReq == 1'b0, "R5 below", txDmaReq, 0);
    txPop = 1'b1; cyc(); txPop = 1'b0;
    cyc(); cyc();
    chk(txDmaReq == 1'b1, "R5 at", txDmaReq, 1);
    begin
      int got = 0;
      while (txDmaReq && got < 20) begin
        txDmaAck = 1'b1; txDmaData = WIDTH'(16'h0300 + got);
        cyc();
        got++;
      end
      txDmaAck = 1'b0;
      chk(got == 3, "R5 burst", got, 3);
      chk(txLevel == DEPTH, "R5 level", txLevel, DEPTH);
    end

    // R8: threshold write while enabled has no effect
    wrReg(2'd1, 3'd0);
    chk(txPopData == 16'h0203, "R11", txPopData, 16'h0203);
    txPop = 1'b1; cyc(); txPop = 1'b0;
    cyc(); cyc();
    chk(txDmaReq == 1'b0, "R8", txDmaReq, 0);

    // R11: remaining order across both fills
    for (int i = 0; i < 7; i++) begin
      int expv;
      expv = (i < 4) ? 16'h0204 + i : 16'h0300 + (i - 4);
      chk(txPopData == WIDTH'(expv), "R11", txPopData, expv);
      txPop = 1'b1;
      cyc();
    end
    txPop = 1'b0;

    // R9: underflow
    chk(txUnderflow == 1'b0, "R9 pre", txUnderflow, 0);
    chk(txPopData == '0, "R9 zero", txPopData, 0);
    txPop = 1'b1; cyc(); txPop = 1'b0;
    chk(txUnderflow == 1'b1, "R9 underflow", txUnderflow, 1);
    chk(txLevel == 0, "R9 level", txLevel, 0);

    // R10: write-one-to-clear
    wrReg(2'd3, 3'b010);
    chk(txUnderflow == 1'b1, "R10 keep", txUnderflow, 1);
    wrReg(2'd3, 3'b001);
    chk(txUnderflow == 1'b0, "R10 clear", txUnderflow, 0);

    // R1 after activity
    doReset();
    chk(txLevel == 0 && txDmaReq == 1'b0, "R1 after run", {txLevel, txDmaReq}, 0);

    // R9: overflow drops the extra word
    for (int i = 0; i < DEPTH + 1; i++) begin
      rxPush = 1'b1; rxPushData = WIDTH'(16'h0400 + i);
      cyc();
    end
    rxPush = 1'b0;
    chk(rxOverflow == 1'b1, "R9 overflow", rxOverflow, 1);
    chk(rxLevel == DEPTH, "R9 rx level", rxLevel, DEPTH);
    wrReg(2'd0, 3'b010);
    begin
      int got = 0;
      for (int k = 0; k < 40 && got < DEPTH; k++) begin
        if (rxDmaReq) begin
          chk(rxDmaData == WIDTH'(16'h0400 + got), "R9 kept", rxDmaData, 16'h0400 + got);
          rxDmaAck = 1'b1;
          got++;
        end
        cyc();
        rxDmaAck = 1'b0;
      end
      chk(got == DEPTH, "R3 drain", got, DEPTH);
    end
    chk(rxOverflow == 1'b1, "R9 sticky", rxOverflow, 1);

    finishRun();
  end
endmodule